// File: doc/BRIEF.md
# Parallel ROM Read Controller

This block sits on the synchronous side of a chip and performs single reads from an asynchronous parallel mask ROM that holds 1M bytes or 512K 16-bit words. A host raises a request with a 20-bit address and a mode flag. The controller latches them, drives the 19 ROM address lines, and asserts chip enable and output enable together, both active low. It holds every pin steady until the access delays have all run out. It then samples the data bus and returns the result with a one-cycle valid pulse. After each access it keeps chip enable and output enable inactive for a set number of cycles, so that the ROM outputs can float before the next access begins.

In byte mode the ROM data pin for bit 15 serves as an address input that lies below address bit 0. The controller drives that pin with the address LSB and returns the low data byte with zeros above it. In word mode that pin is released and all 16 data lines are returned. Three separate cycle counts cover address access, chip-enable access and output-enable access, and a fourth count sets the recovery time.

Top module: `prom_rd_ctrl`

## Requirements
- R1: Out of reset, and at any time the block is idle, ready_o is 1, rom_ce_no and rom_oe_no are 1, rom_lsb_oe_o is 0 and rvalid_o is 0.
- R2: A request is taken on a clock edge where req_i and ready_o are both 1. ready_o is 0 from the next cycle until the block is idle again. req_i has no effect while ready_o is 0, and a req_i held high is served again only after the block has returned to idle.
- R3: From the cycle after acceptance up to and including the capture edge, rom_ce_no and rom_oe_no are both 0. rom_addr_o and rom_lsb_o stay stable during that whole window.
- R4: In word mode (byte_mode_i=0), rom_addr_o equals addr_i[18:0], addr_i[19] is ignored, rom_lsb_oe_o stays 0, and rdata_o returns all 16 bits of rom_d_i.
- R5: In byte mode (byte_mode_i=1), rom_addr_o equals addr_i[19:1], rom_lsb_o carries addr_i[0] with rom_lsb_oe_o at 1 during the access, and rdata_o equals {8'h00, rom_d_i[7:0]}. rom_d_i[15:8] has no effect on rdata_o.
- R6: With T = max(T_AA_CYC, T_CE_CYC, T_OE_CYC), the data is sampled on the (T+2)th clock edge after the acceptance edge. rvalid_o is 1 for exactly the one cycle that follows, and rdata_o holds the sampled value.
- R7: After the capture edge, rom_ce_no and rom_oe_no stay 1 for T_HZ_CYC cycles while ready_o stays 0. ready_o then returns to 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Read request |
| addr_i | input | 20 | Byte address (byte mode) or word address in bits 18:0 (word mode) |
| byte_mode_i | input | 1 | 1 selects byte mode, 0 selects word mode |
| ready_o | output | 1 | Idle and able to accept a request |
| rdata_o | output | 16 | Read result |
| rvalid_o | output | 1 | One-cycle pulse marking rdata_o as new |
| rom_addr_o | output | 19 | ROM address lines |
| rom_ce_no | output | 1 | ROM chip enable, active low |
| rom_oe_no | output | 1 | ROM output enable, active low |
| rom_lsb_o | output | 1 | Value driven onto the shared data-15/address-LSB pin |
| rom_lsb_oe_o | output | 1 | Drive enable for the shared pin |
| rom_d_i | input | 16 | ROM data lines |

## Verification
Each read is launched from a falling edge. The acceptance edge is edge 0. The pin state is checked on the falling edge that follows it. rvalid_o and rdata_o are due exactly T+2 falling edges later, and ready_o is due T_HZ_CYC falling edges after that. The bench counts falling edges and checks the value at each of these exact points, so a pulse that comes early or late fails. The bench ROM model returns a garbage pattern until each of its pins has been active for its own access count, so data sampled too early is caught as a mismatch. Word and byte addresses are swept over both ends of the address range, and a request held high is checked for the spacing between back-to-back reads.

// File: rtl/prom_pkg.sv
package prom_pkg;
  localparam int unsigned ADDR_W  = 20;
  localparam int unsigned WADDR_W = 19;
  localparam int unsigned DATA_W  = 16;
  localparam int unsigned N_ACC   = 3;  // address, chip enable, output enable

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SETUP,
    ST_WAIT,
    ST_CAPTURE,
    ST_RECOVER
  } prom_state_e;
endpackage

// File: rtl/prom_age_cnt.sv
module prom_age_cnt #(
  parameter int unsigned LIMIT = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic active_i,
  output logic done_o
);
  localparam int unsigned CW = (LIMIT < 1) ? 1 : $clog2(LIMIT + 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              cnt_q <= '0;
    else if (!active_i)       cnt_q <= '0;
    else if (cnt_q != CW'(LIMIT)) cnt_q <= cnt_q + 1'b1;
  end

  assign done_o = (cnt_q == CW'(LIMIT));
endmodule

// File: rtl/prom_pin_map.sv
module prom_pin_map
  import prom_pkg::*;
(
  input  logic [ADDR_W-1:0]  addr_i,
  input  logic               byte_i,
  input  logic               active_i,
  input  logic [DATA_W-1:0]  d_i,
  output logic [WADDR_W-1:0] rom_addr_o,
  output logic               lsb_o,
  output logic               lsb_oe_o,
  output logic [DATA_W-1:0]  data_o
);
  always_comb begin
    if (byte_i) begin
      rom_addr_o = addr_i[ADDR_W-1:1];
      lsb_o      = addr_i[0];
      lsb_oe_o   = active_i;
      data_o     = {{(DATA_W-8){1'b0}}, d_i[7:0]};
    end else begin
      rom_addr_o = addr_i[WADDR_W-1:0];
      lsb_o      = 1'b0;
      lsb_oe_o   = 1'b0;
      data_o     = d_i;
    end
  end
endmodule

// File: rtl/prom_rd_ctrl.sv
module prom_rd_ctrl
  import prom_pkg::*;
#(
  parameter int unsigned T_AA_CYC = 10,
  parameter int unsigned T_CE_CYC = 10,
  parameter int unsigned T_OE_CYC = 5,
  parameter int unsigned T_HZ_CYC = 2
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               req_i,
  input  logic [ADDR_W-1:0]  addr_i,
  input  logic               byte_mode_i,
  output logic               ready_o,
  output logic [DATA_W-1:0]  rdata_o,
  output logic               rvalid_o,
  output logic [WADDR_W-1:0] rom_addr_o,
  output logic               rom_ce_no,
  output logic               rom_oe_no,
  output logic               rom_lsb_o,
  output logic               rom_lsb_oe_o,
  input  logic [DATA_W-1:0]  rom_d_i
);
  localparam int unsigned RCW = (T_HZ_CYC < 1) ? 1 : $clog2(T_HZ_CYC + 1);
  localparam logic [RCW-1:0] RC_LAST = RCW'((T_HZ_CYC < 1) ? 0 : T_HZ_CYC - 1);

  prom_state_e state_q, state_d;
  logic [ADDR_W-1:0] addr_q;
  logic              byte_q;
  logic [RCW-1:0]    rc_q;
  logic [N_ACC-1:0]  acc_done;
  logic              active;
  logic [DATA_W-1:0] fmt_data;
  logic [DATA_W-1:0] rdata_q;
  logic              rvalid_q;

  assign active = (state_q == ST_SETUP) || (state_q == ST_WAIT) || (state_q == ST_CAPTURE);

  // one age counter per access path, all started when the pins go active
  for (genvar g = 0; g < N_ACC; g++) begin : g_acc
    localparam int unsigned LIM = (g == 0) ? T_AA_CYC : (g == 1) ? T_CE_CYC : T_OE_CYC;
    prom_age_cnt #(.LIMIT(LIM)) u_cnt (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .active_i (active),
      .done_o   (acc_done[g])
    );
  end

  prom_pin_map u_map (
    .addr_i     (addr_q),
    .byte_i     (byte_q),
    .active_i   (active),
    .d_i        (rom_d_i),
    .rom_addr_o (rom_addr_o),
    .lsb_o      (rom_lsb_o),
    .lsb_oe_o   (rom_lsb_oe_o),
    .data_o     (fmt_data)
  );

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:    if (req_i) state_d = ST_SETUP;
      ST_SETUP:   state_d = ST_WAIT;
      ST_WAIT:    if (&acc_done) state_d = ST_CAPTURE;
      ST_CAPTURE: state_d = ST_RECOVER;
      ST_RECOVER: if (rc_q == RC_LAST) state_d = ST_IDLE;
      default:    state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_IDLE;
      addr_q   <= '0;
      byte_q   <= 1'b0;
      rc_q     <= '0;
      rdata_q  <= '0;
      rvalid_q <= 1'b0;
    end else begin
      state_q  <= state_d;
      rvalid_q <= (state_q == ST_CAPTURE);
      if (state_q == ST_IDLE && req_i) begin
        addr_q <= addr_i;
        byte_q <= byte_mode_i;
      end
      if (state_q == ST_RECOVER) rc_q <= rc_q + 1'b1;
      else                       rc_q <= '0;
      if (state_q == ST_CAPTURE) rdata_q <= fmt_data;
    end
  end

  assign ready_o   = (state_q == ST_IDLE);
  assign rom_ce_no = !active;
  assign rom_oe_no = !active;
  assign rdata_o   = rdata_q;
  assign rvalid_o  = rvalid_q;
endmodule

// File: rtl/prom_rd_chk.sv
module prom_rd_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        req_i,
  input logic        ready_o,
  input logic        rvalid_o,
  input logic [18:0] rom_addr_o,
  input logic        rom_ce_no,
  input logic        rom_oe_no,
  input logic        rom_lsb_o,
  input logic        rom_lsb_oe_o
);
  AST_IDLE_STANDBY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o |-> (rom_ce_no && rom_oe_no && !rom_lsb_oe_o && !rvalid_o)); // R1

  AST_ACCEPT_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && ready_o) |=> (!ready_o && !rom_ce_no)); // R2

  AST_ENABLES_PAIRED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rom_ce_no == rom_oe_no); // R3

  AST_PINS_STABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!rom_ce_no && $past(!rom_ce_no)) |-> ($stable(rom_addr_o) && $stable(rom_lsb_o))); // R3

  AST_LSB_IN_ACCESS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rom_lsb_oe_o |-> !rom_ce_no); // R5

  AST_RVALID_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rvalid_o |=> !rvalid_o); // R6

  AST_RECOVER_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rvalid_o |-> (rom_ce_no && rom_oe_no && !ready_o)); // R7
endmodule

bind prom_rd_ctrl prom_rd_chk u_chk (.*);

// File: tb/sim_prom_rd_ctrl.sv
`timescale 1ns/1ps
module sim_prom_rd_ctrl;
  localparam int unsigned TAA = 3;
  localparam int unsigned TCE = 2;
  localparam int unsigned TOE = 1;
  localparam int unsigned THZ = 2;
  localparam int unsigned TMX = 3;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req_i = 1'b0;
  logic [19:0] addr_i = '0;
  logic        byte_mode_i = 1'b0;
  logic        ready_o, rvalid_o, rom_ce_no, rom_oe_no, rom_lsb_o, rom_lsb_oe_o;
  logic [15:0] rdata_o, rom_d_i;
  logic [18:0] rom_addr_o;

  int checks = 0;
  int errors = 0;
  logic rom_byte = 1'b0;
  int ce_age = 0, oe_age = 0, aa_age = 0;
  logic [19:0] prev_a = '0;
  logic [19:0] cur_a;

  always #2 clk_i = ~clk_i;

  prom_rd_ctrl #(.T_AA_CYC(TAA), .T_CE_CYC(TCE), .T_OE_CYC(TOE), .T_HZ_CYC(THZ)) u0 (
    .clk_i(clk_i), .rst_ni(rst_ni), .req_i(req_i), .addr_i(addr_i),
    .byte_mode_i(byte_mode_i), .ready_o(ready_o), .rdata_o(rdata_o),
    .rvalid_o(rvalid_o), .rom_addr_o(rom_addr_o), .rom_ce_no(rom_ce_no),
    .rom_oe_no(rom_oe_no), .rom_lsb_o(rom_lsb_o), .rom_lsb_oe_o(rom_lsb_oe_o),
    .rom_d_i(rom_d_i)
  );

  function automatic logic [15:0] word_val(input logic [18:0] w);
    logic [31:0] m;
    m = {13'd0, w} * 32'h9E37;
    return m[15:0] ^ {3'd0, w[18:6]} ^ 16'h5A3C;
  endfunction

  // behavioural ROM: garbage until each pin has been active long enough
  assign cur_a = {rom_addr_o, (rom_byte ? rom_lsb_o : 1'b0)};
  always @(posedge clk_i) begin
    ce_age <= rom_ce_no ? 0 : (ce_age < 30 ? ce_age + 1 : ce_age);
    oe_age <= rom_oe_no ? 0 : (oe_age < 30 ? oe_age + 1 : oe_age);
    aa_age <= (cur_a != prev_a) ? 0 : (aa_age < 30 ? aa_age + 1 : aa_age);
    prev_a <= cur_a;
  end

  always_comb begin
    logic [15:0] w;
    w = word_val(rom_addr_o);
    if (rom_ce_no || rom_oe_no || ce_age < TCE || oe_age < TOE || aa_age < TAA ||
        (rom_byte != rom_lsb_oe_o))
      rom_d_i = 16'hDEAD;
    else if (rom_byte)
      rom_d_i = {8'hA5, (rom_lsb_o ? w[15:8] : w[7:0])};
    else
      rom_d_i = w;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_read(input logic [19:0] a, input logic bm);
    logic [15:0] exp;
    int k;
    logic [15:0] w;
    while (!ready_o) @(negedge clk_i);
    rom_byte = bm;
    req_i = 1'b1; addr_i = a; byte_mode_i = bm;
    @(posedge clk_i);
    @(negedge clk_i);
    req_i = 1'b0; addr_i = ~a; byte_mode_i = ~bm;
    chk("R2 ready low after accept", ready_o, 0);
    chk("R3 enables active", {rom_ce_no, rom_oe_no}, 0);
    if (bm) begin
      w = word_val(a[19:1]);
      exp = {8'h00, (a[0] ? w[15:8] : w[7:0])};
      chk("R5 byte address pins", {rom_addr_o, rom_lsb_o, rom_lsb_oe_o}, {a, 1'b1});
    end else begin
      w = word_val(a[18:0]);
      exp = w;
      chk("R4 word address pins", {rom_addr_o, rom_lsb_oe_o}, {a[18:0], 1'b0});
    end
    k = 0;
    while (!rvalid_o && k < 60) begin
      @(negedge clk_i);
      k++;
    end
    chk("R6 rvalid latency", k, TMX + 2);
    chk(bm ? "R5 byte data" : "R4 word data", rdata_o, exp);
    chk("R7 enables off in recovery", {rom_ce_no, rom_oe_no}, 2'b11);
    @(negedge clk_i);
    chk("R6 rvalid single cycle", rvalid_o, 0);
    chk("R6 rdata held", rdata_o, exp);
    for (int j = 1; j < THZ; j++) @(negedge clk_i);
    chk("R7 ready after recovery", ready_o, 1);
    chk("R1 idle pins", {rom_ce_no, rom_oe_no, rom_lsb_oe_o}, 3'b110);
  endtask

  logic fin = 1'b0;

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!fin) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int k;
    int first;
    repeat (3) @(negedge clk_i);
    chk("R1 reset state", {ready_o, rom_ce_no, rom_oe_no, rom_lsb_oe_o, rvalid_o}, 5'b11100);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk("R1 idle after reset", {ready_o, rom_ce_no, rom_oe_no, rom_lsb_oe_o, rvalid_o}, 5'b11100);

    for (int i = 0; i < 64; i++) do_read(20'(i), 1'b0);
    do_read(20'h7FFFF, 1'b0);
    do_read(20'hFFFFF, 1'b0);   // R4 bit 19 ignored
    do_read(20'h8001A, 1'b0);
    for (int i = 0; i < 128; i++) do_read(20'(i), 1'b1);
    do_read(20'hFFFFF, 1'b1);
    do_read(20'hFFFFE, 1'b1);
    do_read(20'h55555, 1'b1);
    do_read(20'h2AAAA, 1'b0);

    // R2: request held high is served back to back, one read per full cycle
    while (!ready_o) @(negedge clk_i);
    rom_byte = 1'b0;
    req_i = 1'b1; addr_i = 20'h00123; byte_mode_i = 1'b0;
    k = 0; first = -1;
    while (k < 40) begin
      @(negedge clk_i);
      k++;
      if (rvalid_o) begin
        if (first < 0) first = k;
        else begin
          chk("R2 held request spacing", k - first, TMX + 3 + THZ);
          chk("R2 second read data", rdata_o, word_val(19'h00123));
          k = 40;
        end
      end
    end
    req_i = 1'b0;
    while (!ready_o) @(negedge clk_i);
    chk("R2 held request produced two reads", first > 0, 1);
    chk("R1 back to idle", {rom_ce_no, rom_oe_no, rvalid_o}, 3'b110);

    fin = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule